// File: doc/BRIEF.md
# Bit Manipulation Execution Unit

This unit performs bit-level operations on 32-bit words, one operation per issue. It counts leading ones or leading zeros, extracts or inserts a bit field at a given position and size, rotates right by an immediate amount or by an amount taken from a register operand, swaps the two bytes inside each halfword, and sign- or zero-extends a byte or halfword.

An issuing pipeline stage presents an operation code, two operands (`rs`, `rt`), and the position, size and shift-amount fields, with `in_valid` high. The result is registered. It appears on `result` with `out_valid` high on the cycle after issue. Between issues the result register holds its last value.

Operation codes on `op`: 0 count leading ones of rs, 1 count leading zeros of rs, 2 extract, 3 insert, 4 rotate right by `sa`, 5 rotate right by rs[4:0], 6 halfword byte swap of rt, 7 sign-extend byte of rt, 8 sign-extend halfword of rt, 9 zero-extend byte of rt, 10 zero-extend halfword of rt. Codes 11 to 15 are unassigned.

Top module: `bmu_top`

## Requirements
- R1: While `rst_n` is low, `result` is 0 and `out_valid` is 0, whatever the other inputs are.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, `result` keeps its value.
- R3: Op 0 returns the number of consecutive ones in rs counted from bit 31 downward, and op 1 does the same for zeros. An all-ones operand (op 0) or an all-zeros operand (op 1) gives 32.
- R4: Op 2 (extract) returns rs[pos+size-1:pos] in the low `size` bits, with all bits above it zero. A size of 0 gives 0. Cases with pos+size above 32 are unspecified.
- R5: Op 3 (insert) returns rt with bits [pos+size-1:pos] replaced by rs[size-1:0]. A size of 0 returns rt unchanged. Cases with pos+size above 32 are unspecified.
- R6: Op 4 returns rt rotated right by `sa` (bit i of the result is rt[(i+sa) mod 32]). An `sa` of 0 returns rt unchanged.
- R7: Op 5 rotates rt right by rs[4:0]. rs[31:5] and `sa` have no effect.
- R8: Op 6 returns the bytes of rt in the order rt[23:16], rt[31:24], rt[7:0], rt[15:8], from most to least significant.
- R9: Op 7 returns rt[7:0] sign-extended to 32 bits, and op 8 returns rt[15:0] sign-extended.
- R10: Op 9 returns rt[7:0] zero-extended, and op 10 returns rt[15:0] zero-extended.
- R11: Unassigned op codes 11 to 15 return 0, with `out_valid` still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe |
| op | input | 4 | Operation code |
| rs | input | 32 | First operand (count source, field source, variable rotate amount) |
| rt | input | 32 | Second operand (insert base, rotate, swap and extend source) |
| pos | input | 5 | Field start bit |
| size | input | 6 | Field width, 0 to 32 |
| sa | input | 5 | Immediate rotate amount |
| result | output | 32 | Registered result |
| out_valid | output | 1 | Result valid, one cycle after issue |

## Verification
All datapath logic feeds a single result register, so a wrong mask, a wrong count scan or a wrong rotate select shows up on `result` in the cycle right after the issuing one. It does so only for operand patterns that reach the faulty bits. The bench therefore aims its stimulus at the boundaries: all-zero and all-ones counts, fields at bit 0 and at bit 31, zero-size fields, and rotates by 0 and by 31. A fault in the load enable or the valid register shows up as a result that changes, or a valid that stays high, in the idle cycle that follows an issue.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [3:0] {
    OP_CLO  = 4'd0,
    OP_CLZ  = 4'd1,
    OP_EXT  = 4'd2,
    OP_INS  = 4'd3,
    OP_ROR  = 4'd4,
    OP_RORV = 4'd5,
    OP_SWAP = 4'd6,
    OP_SEB  = 4'd7,
    OP_SEH  = 4'd8,
    OP_ZEB  = 4'd9,
    OP_ZEH  = 4'd10
  } bmu_op_e;
endpackage

// File: rtl/bmu_lead_count.sv
module bmu_lead_count #(
  parameter int unsigned W = 32,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  // Scan from LSB upward: the highest set bit assigns last and wins.
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bmu_field.sv
module bmu_field #(
  parameter int unsigned W = 32,
  localparam int unsigned PW = $clog2(W),
  localparam int unsigned SW = $clog2(W + 1)
) (
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  base,
  input  logic [PW-1:0] pos,
  input  logic [SW-1:0] size,
  output logic [W-1:0]  extracted,
  output logic [W-1:0]  inserted
);
  logic [W-1:0] low_mask;
  logic [W-1:0] place_mask;

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign low_mask[g] = (SW'(g) < size);
  end

  assign place_mask = low_mask << pos;
  assign extracted  = (src >> pos) & low_mask;
  assign inserted   = (base & ~place_mask) | ((src & low_mask) << pos);
endmodule

// File: rtl/bmu_permute.sv
module bmu_permute #(
  parameter int unsigned W = 32,
  localparam int unsigned PW = $clog2(W),
  localparam int unsigned HW = W / 16
) (
  input  logic [W-1:0]  val,
  input  logic [PW-1:0] amt,
  output logic [W-1:0]  rotated,
  output logic [W-1:0]  swapped,
  output logic [W-1:0]  sext_b,
  output logic [W-1:0]  sext_h,
  output logic [W-1:0]  zext_b,
  output logic [W-1:0]  zext_h
);
  logic [2*W-1:0] doubled;

  assign doubled = {val, val} >> amt;
  assign rotated = doubled[W-1:0];

  for (genvar h = 0; h < HW; h++) begin : g_half
    assign swapped[16*h+15 -: 8] = val[16*h+7  -: 8];
    assign swapped[16*h+7  -: 8] = val[16*h+15 -: 8];
  end

  assign sext_b = {{(W-8){val[7]}}, val[7:0]};
  assign sext_h = {{(W-16){val[15]}}, val[15:0]};
  assign zext_b = {{(W-8){1'b0}}, val[7:0]};
  assign zext_h = {{(W-16){1'b0}}, val[15:0]};
endmodule

// File: rtl/bmu_top.sv
module bmu_top
  import bmu_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  localparam int unsigned PW = $clog2(W),
  localparam int unsigned SW = $clog2(W + 1),
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [W-1:0]  rs,
  input  logic [W-1:0]  rt,
  input  logic [PW-1:0] pos,
  input  logic [SW-1:0] size,
  input  logic [PW-1:0] sa,
  output logic [W-1:0]  result,
  output logic          out_valid
);
  logic [W-1:0]  count_src;
  logic [CW-1:0] lead_cnt;
  logic [W-1:0]  ext_val, ins_val;
  logic [PW-1:0] rot_amt;
  logic [W-1:0]  rot_val, swp_val, seb_val, seh_val, zeb_val, zeh_val;
  logic [W-1:0]  res_d, res_q;
  logic          vld_q;

  // Leading-ones is leading-zeros of the inverted operand.
  assign count_src = (op == OP_CLO) ? ~rs : rs;
  assign rot_amt   = (op == OP_RORV) ? rs[PW-1:0] : sa;

  bmu_lead_count #(.W(W)) i_count (
    .vec   (count_src),
    .zeros (lead_cnt)
  );

  bmu_field #(.W(W)) i_field (
    .src       (rs),
    .base      (rt),
    .pos       (pos),
    .size      (size),
    .extracted (ext_val),
    .inserted  (ins_val)
  );

  bmu_permute #(.W(W)) i_permute (
    .val     (rt),
    .amt     (rot_amt),
    .rotated (rot_val),
    .swapped (swp_val),
    .sext_b  (seb_val),
    .sext_h  (seh_val),
    .zext_b  (zeb_val),
    .zext_h  (zeh_val)
  );

  always_comb begin
    unique case (op)
      OP_CLO, OP_CLZ:  res_d = W'(lead_cnt);
      OP_EXT:          res_d = ext_val;
      OP_INS:          res_d = ins_val;
      OP_ROR, OP_RORV: res_d = rot_val;
      OP_SWAP:         res_d = swp_val;
      OP_SEB:          res_d = seb_val;
      OP_SEH:          res_d = seh_val;
      OP_ZEB:          res_d = zeb_val;
      OP_ZEH:          res_d = zeh_val;
      default:         res_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) res_q <= res_d;
    end
  end

  assign result    = res_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker
  import bmu_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  localparam int unsigned PW = $clog2(W),
  localparam int unsigned SW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic [W-1:0]  rs,
  input logic [W-1:0]  rt,
  input logic [PW-1:0] pos,
  input logic [SW-1:0] size,
  input logic [PW-1:0] sa,
  input logic [W-1:0]  result,
  input logic          out_valid
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  assert_clz_all_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CLZ && rs == '0) |=> result == W);

  assert_clo_all_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CLO && rs == '1) |=> result == W);

  assert_ext_zero_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_EXT && size == '0) |=> result == '0);

  assert_ins_zero_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_INS && size == '0) |=> result == $past(rt));

  assert_rot_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ROR && sa == '0) |=> result == $past(rt));

  assert_rotv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_RORV && rs[PW-1:0] == '0) |=> result == $past(rt));

  assert_seb_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SEB) |=>
      (result[7:0] == $past(rt[7:0]) && result[W-1] == $past(rt[7])));

  assert_zeh_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ZEH) |=>
      (result[W-1:16] == '0 && result[15:0] == $past(rt[15:0])));

  assert_unused_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 4'd10) |=> result == '0);
endmodule

bind bmu_top bmu_checker #(.W(W)) i_bmu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .rs        (rs),
  .rt        (rt),
  .pos       (pos),
  .size      (size),
  .sa        (sa),
  .result    (result),
  .out_valid (out_valid)
);

// File: tb/test_bmu_top.sv
`timescale 1ns/1ps
module test_bmu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [31:0] rs, rt;
  logic [4:0]  pos, sa;
  logic [5:0]  size;
  logic [31:0] result;
  logic        out_valid;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bmu_top i_bmu_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .rs(rs), .rt(rt), .pos(pos), .size(size), .sa(sa),
    .result(result), .out_valid(out_valid)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Independent reference model
  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] a,
      input logic [31:0] b, input int p, input int s, input int r);
    logic [31:0] y;
    int n;
    y = '0;
    case (o)
      4'd0, 4'd1: begin
        n = 0;
        while (n < 32 && a[31-n] == (o == 4'd0)) n++;
        y = n;
      end
      4'd2: for (int i = 0; i < s; i++) y[i] = a[p+i];
      4'd3: begin
        y = b;
        for (int i = 0; i < s; i++) y[p+i] = a[i];
      end
      4'd4, 4'd5: begin
        n = (o == 4'd4) ? r : int'(a[4:0]);
        for (int i = 0; i < 32; i++) y[i] = b[(i+n)%32];
      end
      4'd6:  y = {b[23:16], b[31:24], b[7:0], b[15:8]};
      4'd7:  y = {{24{b[7]}}, b[7:0]};
      4'd8:  y = {{16{b[15]}}, b[15:0]};
      4'd9:  y = {24'h0, b[7:0]};
      4'd10: y = {16'h0, b[15:0]};
      default: y = '0;
    endcase
    return y;
  endfunction

  // Issue one operation, sample one cycle later at the falling edge.
  task automatic issue(input string req, input logic [3:0] o, input logic [31:0] a,
      input logic [31:0] b, input int p, input int s, input int r);
    @(negedge clk);
    op = o; rs = a; rt = b; pos = 5'(p); size = 6'(s); sa = 5'(r);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {31'h0, out_valid}, 32'h1);
    chk(req, result, model(o, a, b, p, s, r));
  endtask

  task automatic test_reset();
    rst_n = 1'b0; in_valid = 1'b1; op = 4'd6; rs = 32'hFFFF_FFFF; rt = 32'h1234_5678;
    pos = '0; size = '0; sa = '0;
    repeat (3) @(negedge clk);
    chk("R1 result in reset", result, 32'h0);
    chk("R1 valid in reset", {31'h0, out_valid}, 32'h0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_count();
    issue("R3 clz zero",     4'd1, 32'h0000_0000, 0, 0, 0, 0);
    issue("R3 clz mid",      4'd1, 32'h0000_8000, 0, 0, 0, 0);
    issue("R3 clz msb",      4'd1, 32'h8000_0000, 0, 0, 0, 0);
    issue("R3 clo ones",     4'd0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    issue("R3 clo four",     4'd0, 32'hF0F0_0000, 0, 0, 0, 0);
    issue("R3 clo none",     4'd0, 32'h7FFF_FFFF, 0, 0, 0, 0);
  endtask

  task automatic test_extract();
    issue("R4 ext byte",     4'd2, 32'hDEAD_BEEF, 32'h5555_5555, 4, 8, 0);
    issue("R4 ext full",     4'd2, 32'hDEAD_BEEF, 0, 0, 32, 0);
    issue("R4 ext top",      4'd2, 32'hDEAD_BEEF, 0, 28, 4, 0);
    issue("R4 ext size0",    4'd2, 32'hDEAD_BEEF, 0, 7, 0, 0);
  endtask

  task automatic test_insert();
    issue("R5 ins byte",     4'd3, 32'h0000_ABCD, 32'h1234_5678, 8, 8, 0);
    issue("R5 ins full",     4'd3, 32'hCAFE_F00D, 32'h1234_5678, 0, 32, 0);
    issue("R5 ins size0",    4'd3, 32'hFFFF_FFFF, 32'h1234_5678, 3, 0, 0);
    issue("R5 ins bit31",    4'd3, 32'h0000_0001, 32'h0000_0000, 31, 1, 0);
  endtask

  task automatic test_rotate();
    issue("R6 ror 4",        4'd4, 32'hFFFF_FFFF, 32'h1234_5678, 0, 0, 4);
    issue("R6 ror 0",        4'd4, 32'h0000_0007, 32'h1234_5678, 0, 0, 0);
    issue("R6 ror 31",       4'd4, 32'h0, 32'h1234_5678, 0, 0, 31);
  endtask

  task automatic test_rotate_var();
    issue("R7 rorv 8",       4'd5, 32'hFFFF_FFE8, 32'h1234_5678, 0, 0, 3);
    issue("R7 rorv upper",   4'd5, 32'h0000_0020, 32'h1234_5678, 0, 0, 17);
    issue("R7 rorv 1",       4'd5, 32'hA5A5_A5A1, 32'h8000_0001, 0, 0, 0);
  endtask

  task automatic test_swap();
    issue("R8 swap",         4'd6, 0, 32'h1122_3344, 0, 0, 0);
    issue("R8 swap b",       4'd6, 0, 32'hFF00_00FF, 0, 0, 0);
  endtask

  task automatic test_extend();
    issue("R9 seb neg",      4'd7, 0, 32'h0000_00F0, 0, 0, 0);
    issue("R9 seb pos",      4'd7, 0, 32'hABCD_007F, 0, 0, 0);
    issue("R9 seh neg",      4'd8, 0, 32'h1234_8000, 0, 0, 0);
    issue("R10 zeb",         4'd9, 0, 32'hFFFF_FFF0, 0, 0, 0);
    issue("R10 zeh",         4'd10, 0, 32'h1234_8000, 0, 0, 0);
  endtask

  task automatic test_unused();
    issue("R11 op 11",       4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 3, 5);
    issue("R11 op 15",       4'd15, 32'h1234_5678, 32'h9ABC_DEF0, 0, 8, 2);
  endtask

  task automatic test_hold();
    logic [31:0] exp;
    issue("R2 setup", 4'd6, 0, 32'hA1B2_C3D4, 0, 0, 0);
    exp = 32'hB2A1_D4C3;
    op = 4'd9; rt = 32'h0; rs = 32'h0;
    repeat (2) @(negedge clk);
    chk("R2 hold result", result, exp);
    chk("R2 valid drops", {31'h0, out_valid}, 32'h0);
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    test_reset();
    test_count();
    test_extract();
    test_insert();
    test_rotate();
    test_rotate_var();
    test_swap();
    test_extend();
    test_unused();
    test_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule